// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects sixteen interrupt request lines. Each line has a fixed priority level, numbered 0 to 15, and level 15 is the most urgent. A one-cycle pulse on a line's event input sets a pending flag for that line. The flag stays set until the processor services it. The arbiter then chooses among the eligible pending flags and drives a request strobe to the core, together with the vector address of the chosen level. Level L has vector `0xFFE0 + 2*L`, so every level owns one 16-bit word at the top of the address space.

The two highest levels are non-maskable. They ignore both the per-line enable bits and the global enable. Every level below them needs two things to be eligible: its own enable bit in the enable register, and the global enable input. The core answers the request with a one-cycle acknowledge. On that edge the block clears the flag of the level whose vector is on the bus. Software writes and reads the enable register through a plain word port with a write strobe.

Top module: `vpic_top`

## Requirements
- R1: After reset no flag is pending, `irq_req_o` is low, and `en_rdata_o` reads 0xC000: every maskable enable is off.
- R2: A pulse on `evt_i[L]` sets the pending flag of level L. The flag shows at the outputs from the next cycle on.
- R3: While `irq_req_o` is high, `irq_vec_o` equals 0xFFE0 + 2*L, where L is the presented level. Level 15 gives 0xFFFE and level 0 gives 0xFFE0.
- R4: When several eligible flags are pending, the highest-numbered level is presented and the lower ones stay pending.
- R5: Pending flags at levels 15 and 14 are presented even when every enable bit is clear and `glb_en_i` is low.
- R6: A pending level from 0 to 13 is eligible only while its enable bit is 1 and `glb_en_i` is 1.
- R7: When `irq_ack_i` is high and `irq_req_o` is high at a rising edge, the flag of the presented level clears and no other flag changes.
- R8: If an event for the presented level arrives on the same edge as its acknowledge, the flag stays set.
- R9: Writes with `en_we_i` high update enable bits 13 to 0 from `en_wdata_i`. Bits 15 and 14 ignore writes and always read 1.
- R10: An `irq_ack_i` pulse while `irq_req_o` is low clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event pulses, bit L sets the flag of level L |
| glb_en_i | input | 1 | Global enable for maskable levels |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 16 | Enable register write data |
| en_rdata_o | output | 16 | Enable register read data |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Vector address of the presented level |
| irq_ack_i | input | 1 | One-cycle acknowledge from the core |

## Verification
The bench builds the block with its default parameters: sixteen levels, two non-maskable levels, a 16-bit address, base 0xFFE0 and a two-byte stride. These values put both ends of the vector range within reach, as well as the boundary between maskable and non-maskable levels at 13/14. The bench also covers an event that collides with its own acknowledge. A behavioural model tracks the flags and enables as plain bit vectors and is compared against the request, vector and read data on every cycle, under both directed and random traffic.

// File: rtl/vpic_pkg.sv
`timescale 1ns/1ps
package vpic_pkg;
   localparam int unsigned VPIC_LEVELS_DFLT = 16;
   localparam int unsigned VPIC_NMI_DFLT    = 2;
   localparam int unsigned VPIC_ADDR_W_DFLT = 16;
   localparam int unsigned VPIC_BASE_DFLT   = 32'hFFE0;
   localparam int unsigned VPIC_SHIFT_DFLT  = 1;

   // byte offset of a level's vector slot
   function automatic int unsigned vpic_offset(input int unsigned lvl, input int unsigned shift);
      return lvl << shift;
   endfunction
endpackage

// File: rtl/vpic_pending.sv
`timescale 1ns/1ps
module vpic_pending #(
   parameter int unsigned N_LEVELS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] evt_i,
   input  logic [N_LEVELS-1:0] clr_i,
   output logic [N_LEVELS-1:0] pend_o
);
   for (genvar i = 0; i < N_LEVELS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_o[i] <= 1'b0;
         else if (evt_i[i])
            pend_o[i] <= 1'b1;
         else if (clr_i[i])
            pend_o[i] <= 1'b0;
      end

      // R2 R8
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> pend_o[i]);
      // R7
      clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !evt_i[i]) |=> !pend_o[i]);
   end
endmodule

// File: rtl/vpic_enable.sv
`timescale 1ns/1ps
module vpic_enable #(
   parameter int unsigned N_LEVELS = 16,
   parameter int unsigned N_NMI    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [N_LEVELS-1:0] wdata_i,
   output logic [N_LEVELS-1:0] ena_o
);
   localparam int unsigned N_MASK = N_LEVELS - N_NMI;

   for (genvar i = 0; i < N_LEVELS; i++) begin : g_bit
      if (i >= N_MASK) begin : g_fixed
         assign ena_o[i] = 1'b1;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ena_o[i] <= 1'b0;
            else if (we_i)
               ena_o[i] <= wdata_i[i];
         end
      end
   end

   // R9
   wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ena_o[N_MASK-1:0] == $past(wdata_i[N_MASK-1:0]));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(ena_o));
endmodule

// File: rtl/vpic_arbiter.sv
`timescale 1ns/1ps
module vpic_arbiter #(
   parameter int unsigned N_LEVELS = 16,
   parameter int unsigned LVL_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] elig_i,
   output logic                valid_o,
   output logic [LVL_W-1:0]    sel_o
);
   // ascending scan: last hit is the highest level
   always_comb begin
      valid_o = 1'b0;
      sel_o   = '0;
      for (int i = 0; i < N_LEVELS; i++) begin
         if (elig_i[i]) begin
            valid_o = 1'b1;
            sel_o   = LVL_W'(i);
         end
      end
   end

   // R4
   top_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (elig_i >> sel_o) == N_LEVELS'(1));
   // R4
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> elig_i == '0);
endmodule

// File: rtl/vpic_top.sv
`timescale 1ns/1ps
module vpic_top
   import vpic_pkg::*;
#(
   parameter int unsigned N_LEVELS  = VPIC_LEVELS_DFLT,
   parameter int unsigned N_NMI     = VPIC_NMI_DFLT,
   parameter int unsigned ADDR_W    = VPIC_ADDR_W_DFLT,
   parameter int unsigned VEC_BASE  = VPIC_BASE_DFLT,
   parameter int unsigned VEC_SHIFT = VPIC_SHIFT_DFLT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LEVELS-1:0] evt_i,
   input  logic                glb_en_i,
   input  logic                en_we_i,
   input  logic [N_LEVELS-1:0] en_wdata_i,
   output logic [N_LEVELS-1:0] en_rdata_o,
   output logic                irq_req_o,
   output logic [ADDR_W-1:0]   irq_vec_o,
   input  logic                irq_ack_i
);
   localparam int unsigned LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1;
   localparam logic [N_LEVELS-1:0] NMI_MASK = ~({N_LEVELS{1'b1}} >> N_NMI);
   localparam logic [ADDR_W-1:0] TOP_VEC =
      ADDR_W'(VEC_BASE + vpic_offset(N_LEVELS - 1, VEC_SHIFT));

   if (N_LEVELS < 2 || N_LEVELS > 32) begin : g_bad_levels
      $error("vpic_top: N_LEVELS must lie in 2..32");
   end
   if (N_NMI >= N_LEVELS) begin : g_bad_nmi
      $error("vpic_top: N_NMI must leave at least one maskable level");
   end
   if (VEC_BASE + vpic_offset(N_LEVELS, VEC_SHIFT) > (64'd1 << ADDR_W)) begin : g_bad_vec
      $error("vpic_top: vector table overruns the address space");
   end

   logic [N_LEVELS-1:0] ena;
   logic [N_LEVELS-1:0] pend;
   logic [N_LEVELS-1:0] elig;
   logic [N_LEVELS-1:0] clr;
   logic                valid;
   logic [LVL_W-1:0]    sel;

   vpic_enable #(.N_LEVELS(N_LEVELS), .N_NMI(N_NMI)) u_enable (
      .clk(clk), .rst_n(rst_n), .we_i(en_we_i), .wdata_i(en_wdata_i), .ena_o(ena)
   );

   vpic_pending #(.N_LEVELS(N_LEVELS)) u_pending (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .pend_o(pend)
   );

   assign elig = pend & ena & (glb_en_i ? {N_LEVELS{1'b1}} : NMI_MASK);

   vpic_arbiter #(.N_LEVELS(N_LEVELS), .LVL_W(LVL_W)) u_arbiter (
      .clk(clk), .rst_n(rst_n), .elig_i(elig), .valid_o(valid), .sel_o(sel)
   );

   assign clr        = (irq_ack_i && valid) ? (N_LEVELS'(1) << sel) : '0;
   assign irq_req_o  = valid;
   assign irq_vec_o  = ADDR_W'(VEC_BASE) + (ADDR_W'(sel) << VEC_SHIFT);
   assign en_rdata_o = ena;

   // R5
   nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[N_LEVELS-1] |-> (irq_req_o && irq_vec_o == TOP_VEC));
   // R6
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en_i && irq_req_o) |-> (32'(sel) >= N_LEVELS - N_NMI));
   // R10
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !irq_req_o) |=> pend == ($past(pend) | $past(evt_i)));
   // R3
   vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (irq_vec_o >= ADDR_W'(VEC_BASE) && irq_vec_o <= TOP_VEC));
endmodule

// File: tb/test_vpic_top.sv
`timescale 1ns/1ps
module test_vpic_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] evt;
   logic        gie;
   logic        we;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic        req;
   logic [15:0] vec;
   logic        ack;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   vpic_top i_vpic_top (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .glb_en_i(gie), .en_we_i(we),
      .en_wdata_i(wdata), .en_rdata_o(rdata), .irq_req_o(req), .irq_vec_o(vec),
      .irq_ack_i(ack)
   );

   // behavioural reference
   bit [15:0] m_pend;
   bit [15:0] m_en;

   function automatic int m_pick();
      for (int l = 15; l >= 0; l--)
         if (m_pend[l] && (l >= 14 || (gie && m_en[l]))) return l;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend = '0;
         m_en   = '0;
      end else begin
         int s;
         s = m_pick();
         if (ack && s >= 0) m_pend[s] = 1'b0;
         m_pend = m_pend | evt;
         if (we) m_en = wdata & 16'h3FFF;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      int s;
      s = m_pick();
      chk("R4/R6 model irq_req", 32'(req), 32'(s >= 0));
      if (s >= 0) chk("R3 model vector", 32'(vec), 32'h0000FFE0 + 32'(2 * s));
      chk("R9 model rdata", 32'(rdata), 32'(m_en | 16'hC000));
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      compare();
   endtask

   task automatic pulse(input logic [15:0] e);
      evt = e; tick(); evt = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic wr(input logic [15:0] d);
      we = 1'b1; wdata = d; tick(); we = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; evt = '0; gie = 1'b0; we = 1'b0; wdata = '0; ack = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset irq_req", 32'(req), 0);
      chk("R1 reset rdata", 32'(rdata), 32'hC000);
      rst_n = 1'b1;
      tick();
      chk("R1 idle after reset", 32'(req), 0);

      // R6: enable off
      gie = 1'b1;
      pulse(16'h0020);
      chk("R6 disabled level silent", 32'(req), 0);
      wr(16'h0020);
      chk("R9 rdata after write", 32'(rdata), 32'hC020);
      chk("R6 enabled level requests", 32'(req), 1);
      chk("R3 level5 vector", 32'(vec), 32'hFFEA);
      gie = 1'b0; tick();
      chk("R6 global enable off", 32'(req), 0);
      gie = 1'b1; tick();
      // R7
      do_ack();
      chk("R7 ack clears presented", 32'(req), 0);

      // R2 R4
      wr(16'h0204);
      pulse(16'h0204);
      chk("R2 flag visible next cycle", 32'(req), 1);
      chk("R4 highest picked", 32'(vec), 32'hFFF2);
      do_ack();
      chk("R4 lower stays pending", 32'(req), 1);
      chk("R4 lower vector", 32'(vec), 32'hFFE4);
      do_ack();
      chk("R7 all cleared", 32'(req), 0);

      // R5
      gie = 1'b0; wr(16'h0000);
      pulse(16'h4000);
      chk("R5 level14 unmasked", 32'(vec), 32'hFFFC);
      pulse(16'h8000);
      chk("R5 level15 vector", 32'(vec), 32'hFFFE);
      do_ack();
      chk("R5 back to level14", 32'(vec), 32'hFFFC);
      do_ack();
      chk("R5 nmi cleared", 32'(req), 0);

      // R8
      gie = 1'b1; wr(16'h0004);
      pulse(16'h0004);
      ack = 1'b1; evt = 16'h0004; tick(); ack = 1'b0; evt = '0;
      chk("R8 event beats ack req", 32'(req), 1);
      chk("R8 event beats ack vec", 32'(vec), 32'hFFE4);
      do_ack();
      chk("R8 later ack clears", 32'(req), 0);

      // R10
      wr(16'h0000);
      pulse(16'h0010);
      chk("R10 masked pending silent", 32'(req), 0);
      do_ack();
      wr(16'h0010);
      chk("R10 idle ack kept flag", 32'(req), 1);
      chk("R10 vector level4", 32'(vec), 32'hFFE8);
      do_ack();

      // R3 bottom
      wr(16'h0001);
      pulse(16'h0001);
      chk("R3 level0 vector", 32'(vec), 32'hFFE0);
      do_ack();

      // R9
      wr(16'hFFFF);
      chk("R9 all ones", 32'(rdata), 32'hFFFF);
      wr(16'h1234);
      chk("R9 top bits fixed", 32'(rdata), 32'hD234);
      wr(16'h0000);
      chk("R9 cleared", 32'(rdata), 32'hC000);

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         evt = 16'($urandom & $urandom & $urandom);
         if ($urandom_range(0, 49) == 0) gie = ~gie;
         we = ($urandom_range(0, 19) == 0);
         wdata = 16'($urandom);
         ack = (m_pick() >= 0) && ($urandom_range(0, 2) == 0);
         tick();
      end
      evt = '0; we = 1'b0; ack = 1'b0;
      tick();

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule